// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block takes bitstream entries from a show-ahead FIFO and sends them one bit at a time to the serial configuration pins of a programmable logic device. Each entry holds a 32-bit data word, a 2-bit size code and a final-entry marker. The block makes the configuration clock itself by dividing the system clock with a divider value. It reads that value again at the start of every entry.

The controller fetches an entry whenever it is idle and the FIFO holds data. It shifts out the bytes that the size code selects and then fetches the next entry on the same clock edge, so the configuration clock keeps running between entries. After the final bit of an entry marked as final, it raises a done flag and stops fetching. A restart pulse clears the flag and lets the block load another stream.

Top module: `cfg_serial_loader`

## Requirements
- R1: With divider value D (latched at fetch), the configuration clock stays low for D+1 system cycles and then high for D+1 system cycles, giving a period of 2*(D+1) cycles. The period stays the same across an entry boundary when the next entry is fetched back to back.
- R2: An entry with 2-bit size code S sends exactly 8*(S+1) bits: code 0 sends one byte and code 3 sends the whole 32-bit word.
- R3: The bytes of a word go out starting at bits [7:0] and moving upward, and each byte goes out least significant bit first.
- R4: The serial data output changes only while the configuration clock is low, at a falling edge or at a fetch. It is stable at every rising edge.
- R5: When no entry is in progress, the configuration clock is held low. Every clock pulse is complete.
- R6: The FIFO read strobe is high for one cycle per entry and never while the FIFO is empty. A fetch happens while idle, or on the falling edge that ends the final bit of an entry not marked final.
- R7: The done flag rises on the falling edge that ends the final bit of an entry marked final. While the flag is set, no entry is read and the clock stays low.
- R8: A restart pulse while done clears the flag, and the block goes back to fetching entries.
- R9: A change of the divider input during an entry has no effect until the next fetch.
- R10: After reset the configuration clock is low, done is low and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_data_i | input | 32 | Data word at the head of the FIFO |
| fifo_size_i | input | 2 | Byte count code of the head entry (0 = 1 byte, 3 = 4 bytes) |
| fifo_last_i | input | 1 | Head entry is the final entry of the stream |
| fifo_empty_i | input | 1 | FIFO holds no entry |
| fifo_rd_o | output | 1 | Pops the head entry at the next clock edge |
| clkdiv_i | input | 8 | Divider value D, latched at each fetch |
| restart_i | input | 1 | Clears done and re-arms fetching |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_dat_o | output | 1 | Serial configuration data |
| done_o | output | 1 | Final entry has been sent |

## Verification
The read strobe depends combinationally on the current inputs and state, so it is due in the same cycle as the FIFO and state conditions that call for it. The configuration clock rises D+1 edges after a fetch and falls D+1 edges later. Done rises on the same edge as the final falling clock. A behavioural model in the bench advances once per system clock from the inputs that were present at that edge. The bench compares the model with every output 2 ns after each falling system edge, when all registers have settled and the stimulus, driven 1 ns after the falling edge, stays stable until the next rising edge. A receiver samples the data at each rising configuration clock edge and checks the bit order and the edge-to-edge intervals.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfg_ld_halfper.sv
// Half-period timer: reloads from the value latched at the last load.
module cfg_ld_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] val_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             cnt_en, rel_en;

  assign tick_o = run_i && (cnt_q == '0);
  assign rel_en = load_i;
  assign cnt_en = load_i || run_i;

  always_comb begin
    rel_d = val_i;
    if (load_i)             cnt_d = val_i;
    else if (cnt_q == '0)   cnt_d = rel_q;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rel_en) rel_q <= rel_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_q <= rel_q); // R1
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_i && !load_i |=> $stable(rel_q)); // R9
endmodule

// File: rtl/cfg_ld_shreg.sv
// Word shift register with a bit counter loaded from the byte-count code.
module cfg_ld_shreg #(
  parameter int W    = 32,
  parameter int SZ_W = $clog2(W / 8)
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [W-1:0]    data_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            shift_i,
  output logic            bit_o,
  output logic            last_bit_o
);
  localparam int BIT_W = SZ_W + 3;

  logic [W-1:0]     sr_q, sr_d;
  logic [BIT_W-1:0] left_q, left_d;
  logic             en;

  assign en         = load_i || shift_i;
  assign bit_o      = sr_q[0];
  assign last_bit_o = (left_q == '0);

  always_comb begin
    if (load_i) begin
      sr_d   = data_i;
      left_d = {size_i, 3'b111};
    end else begin
      sr_d   = {1'b0, sr_q[W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  AST_NO_SHIFT_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_n)
    shift_i |-> !last_bit_o); // R2
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ld_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIV_W = 8,
  localparam int SZ_W = $clog2(W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     fifo_data_i,
  input  logic [SZ_W-1:0]  fifo_size_i,
  input  logic             fifo_last_i,
  input  logic             fifo_empty_i,
  output logic             fifo_rd_o,
  input  logic [DIV_W-1:0] clkdiv_i,
  input  logic             restart_i,
  output logic             cfg_clk_o,
  output logic             cfg_dat_o,
  output logic             done_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  ld_state_e st_q, st_d;
  logic      clk_q, clk_d, last_q;
  logic      tick, last_bit, take, shift, fetch;

  cfg_ld_halfper #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .load_i (fetch),
    .val_i  (clkdiv_i),
    .run_i  (st_q == ST_SHIFT),
    .tick_o (tick)
  );

  cfg_ld_shreg #(.W(W), .SZ_W(SZ_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .load_i     (fetch),
    .data_i     (fifo_data_i),
    .size_i     (fifo_size_i),
    .shift_i    (shift),
    .bit_o      (cfg_dat_o),
    .last_bit_o (last_bit)
  );

  // fetch while idle, or at the falling edge that ends a non-final entry
  assign take  = (st_q == ST_IDLE) ||
                 ((st_q == ST_SHIFT) && tick && clk_q && last_bit && !last_q);
  assign fetch = take && !fifo_empty_i;
  assign shift = (st_q == ST_SHIFT) && tick && clk_q && !last_bit;
  assign fifo_rd_o = fetch;

  always_comb begin
    st_d  = st_q;
    clk_d = clk_q;
    unique case (st_q)
      ST_IDLE: if (fetch) st_d = ST_SHIFT;
      ST_SHIFT: begin
        if (tick) begin
          clk_d = !clk_q;
          if (clk_q && last_bit) begin
            if (last_q)      st_d = ST_DONE;
            else if (!fetch) st_d = ST_IDLE;
          end
        end
      end
      ST_DONE: if (restart_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (fetch) clk_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      clk_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clk_q <= clk_d;
      if (fetch) last_q <= fifo_last_i;
    end
  end

  assign cfg_clk_o = clk_q;
  assign done_o    = (st_q == ST_DONE);

  AST_RD_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i); // R6
  AST_DAT_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(cfg_clk_o) |-> $stable(cfg_dat_o)); // R4
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q != ST_SHIFT) |-> !cfg_clk_o); // R5
  AST_DONE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !fifo_rd_o); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o && restart_i |=> !done_o); // R8
endmodule

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
  typedef struct { logic [31:0] d; logic [1:0] s; logic l; } ent_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fifo_data_i = '0;
  logic [1:0]  fifo_size_i = '0;
  logic        fifo_last_i = 1'b0;
  logic        fifo_empty_i = 1'b1;
  logic        fifo_rd_o;
  logic [7:0]  clkdiv_i = '0;
  logic        restart_i = 1'b0;
  logic        cfg_clk_o, cfg_dat_o, done_o;

  cfg_serial_loader u0 (.*);

  always #5 clk_i = ~clk_i;

  int   checks = 0, fails = 0, cyc = 0;
  bit   finished = 0;
  ent_t q[$];
  bit   exp_bits[$];
  bit   rx_bits[$];
  longint ivs[$];
  longint last_rise = -1;

  // model state
  int m_busy = 0, m_done = 0, m_ph = 0, m_bit = 0, m_nb = 0, m_div = 0, m_last = 0;
  logic [31:0] m_word = '0;
  int p_pop = 0, p_rst = 0, p_div = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  task automatic refresh();
    fifo_empty_i = (q.size() == 0);
    if (q.size() != 0) begin
      fifo_data_i = q[0].d; fifo_size_i = q[0].s; fifo_last_i = q[0].l;
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [1:0] s, input logic l);
    ent_t e;
    e.d = d; e.s = s; e.l = l;
    q.push_back(e);
    for (int i = 0; i < 8 * (int'(s) + 1); i++) exp_bits.push_back(d[i]);
    refresh();
  endtask

  task automatic step(); @(negedge clk_i); #1; endtask
  task automatic steps(input int n); for (int i = 0; i < n; i++) step(); endtask

  task automatic clear_rx();
    rx_bits.delete(); exp_bits.delete(); ivs.delete(); last_rise = -1;
  endtask

  task automatic wait_done();
    while (!done_o) step();
    step();
  endtask

  task automatic check_rx();
    bit same = 1;
    chk(rx_bits.size() == exp_bits.size(), "R2 bit count", rx_bits.size(), exp_bits.size());
    for (int i = 0; i < rx_bits.size() && i < exp_bits.size(); i++)
      if (rx_bits[i] != exp_bits[i]) same = 0;
    chk(same, "R3 bit order", same, 1);
  endtask

  task automatic check_ivs(input string req, input longint want);
    bit ok = (ivs.size() > 0);
    longint bad = want;
    foreach (ivs[i]) if (ivs[i] != want) begin ok = 0; bad = ivs[i]; end
    chk(ok, req, bad, want);
  endtask

  // receiver on the configuration clock
  always @(posedge cfg_clk_o) begin
    rx_bits.push_back(cfg_dat_o);
    if (last_rise >= 0) ivs.push_back($time - last_rise);
    last_rise = $time;
  end

  // per-cycle reference model
  always begin
    @(negedge clk_i); #2;
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; p_pop = 0; p_rst = 0;
    end else begin
      int period;
      period = 2 * (m_div + 1);
      if (m_busy != 0) begin
        if (m_ph == period - 1) begin
          if (m_bit == m_nb - 1) begin
            if (m_last != 0) begin m_busy = 0; m_done = 1; end
            else if (p_pop == 0) m_busy = 0;
          end else begin m_bit++; m_ph = 0; end
        end else m_ph++;
      end else if (m_done != 0) begin
        if (p_rst != 0) m_done = 0;
      end
      if (p_pop != 0) begin
        ent_t e;
        e = q.pop_front();
        m_word = e.d; m_nb = 8 * (int'(e.s) + 1); m_last = e.l;
        m_div = p_div; m_bit = 0; m_ph = 0; m_busy = 1;
        refresh();
      end
      // outputs after this edge
      begin
        bit ck;
        ck = (m_busy != 0) && (m_ph >= m_div + 1);
        chk(cfg_clk_o == ck, (m_busy != 0) ? "R1 cfg clock" : "R5 idle clock", cfg_clk_o, ck);
        chk(done_o == (m_done != 0), "R7 done", done_o, m_done);
        if (m_busy != 0) chk(cfg_dat_o == m_word[m_bit], "R4 data", cfg_dat_o, m_word[m_bit]);
      end
      // decision for next edge
      p_pop = (q.size() != 0) &&
              (((m_busy == 0) && (m_done == 0)) ||
               ((m_busy != 0) && (m_ph == 2 * (m_div + 1) - 1) && (m_bit == m_nb - 1) && (m_last == 0)));
      p_div = clkdiv_i;
      p_rst = restart_i;
      chk(fifo_rd_o == p_pop[0], "R6 read strobe", fifo_rd_o, p_pop);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    steps(3);
    rst_ni = 1'b1;
    steps(6);
    // R10: reset state
    chk(cfg_clk_o == 0, "R10 clock low", cfg_clk_o, 0);
    chk(done_o == 0, "R10 done low", done_o, 0);
    chk(fifo_rd_o == 0, "R10 no read", fifo_rd_o, 0);

    // R1/R6: two entries back to back, divider 0
    clear_rx();
    clkdiv_i = 8'd0;
    push(32'hA5C3_0F96, 2'd0, 1'b0);
    push(32'h0000_3C81, 2'd1, 1'b1);
    wait_done();
    check_rx();
    check_ivs("R1 period across entries", 20);
    chk(done_o == 1, "R7 done after final", done_o, 1);

    // R7: entries ignored while done
    clear_rx();
    clkdiv_i = 8'd1;
    push(32'h1234_5678, 2'd3, 1'b0);
    steps(20);
    chk(q.size() == 1, "R7 no read while done", q.size(), 1);
    chk(cfg_clk_o == 0, "R7 clock held low", cfg_clk_o, 0);

    // R8: restart resumes; R5: idle gap between entries
    restart_i = 1'b1; step(); restart_i = 1'b0;
    steps(200);
    chk(done_o == 0, "R8 done cleared", done_o, 0);
    chk(cfg_clk_o == 0, "R5 clock low in gap", cfg_clk_o, 0);
    push(32'h00AB_CDEF, 2'd2, 1'b1);
    wait_done();
    check_rx();

    // R9: divider change mid-entry ignored
    restart_i = 1'b1; step(); restart_i = 1'b0;
    clear_rx();
    clkdiv_i = 8'd2;
    push(32'h0000_005A, 2'd0, 1'b1);
    steps(10);
    clkdiv_i = 8'd5;
    wait_done();
    check_rx();
    check_ivs("R9 divider held", 60);

    steps(4);
    summary();
    $finish;
  end
endmodule